// File: doc/BRIEF.md
# Indexed Addressing Effective-Address Generator

This block turns one indexed-mode postbyte into a 16-bit effective address. A request carries the postbyte, a 16-bit extension word and a restricted-mode flag. It also carries a snapshot of the four base registers (X, Y, SP, PC) and the accumulators A, B and D. The block picks one of seven address forms from the postbyte. These are a short signed offset, auto-modify, a 9-bit offset, a 16-bit offset, an accumulator offset, and two memory-indirect forms. It reports the address together with a base-register writeback and the number of extra cycles the form costs.

The two indirect forms fetch a 16-bit pointer through a request/acknowledge memory port. That port may hold off the acknowledge for any number of cycles. Every result is presented with a one-cycle `done` pulse. A new request is taken only while `req_ready` is high, and it stays low from the accept until `done`.

Top module: `idx_ea_gen`

## Requirements
- R1: When postbyte bit 5 is 0, the address is base + sign-extended bits 4:0. The base is chosen by bits 7:6 (0 = X, 1 = Y, 2 = SP, 3 = PC). No writeback, extra cycles 0.
- R2: When bit 5 is 1 and bits 7:6 are not 11, the form is auto-modify. With bit 3 set, the amount is the sign-extended nibble 3:0 (-8..-1). With bit 3 clear, the amount is nibble + 1 (+1..+8). The base chosen by bits 7:6 is written back with base + amount (`wb_sel` = bits 7:6). Extra cycles 0.
- R3: In auto-modify, bit 4 = 0 gives the updated value as the address (pre-modify). Bit 4 = 1 gives the original base (post-modify).
- R4: When bits 7:6 = 11, bits 4:3 choose the base with the R1 encoding. Bits 2:0 = 000 or 001 give base + {8 copies of bit 0, ext_word[7:0]}, with extra cycles 1.
- R5: Bits 7:6 = 11 with bits 2:0 = 010 give base + ext_word, with extra cycles 1.
- R6: Bits 7:6 = 11 with bits 2:0 = 011 read the word at base + ext_word. That word is the address. Extra cycles 1. This pattern takes priority over R5.
- R7: Bits 7:6 = 11 with bits 2:0 = 100, 101 or 110 give base plus zero-extended A, zero-extended B, or D respectively. Extra cycles 0.
- R8: Bits 7:6 = 11 with bits 2:0 = 111 read the word at base + D. That word is the address. Extra cycles 1.
- R9: With `restricted` high, the R4, R5, R6 and R8 forms return address 0 with no writeback, extra cycles 0 and no memory request. The R1, R2/R3 and R7 forms are unaffected.
- R10: All address sums wrap modulo 2^16.
- R11: `req_ready` is high only while idle. A direct form raises `done` exactly one cycle after the accept. An indirect form holds `mem_req` with a stable `mem_addr` until `mem_ack`, then raises `done` the following cycle. `done` lasts one cycle.
- R12: `wb_en` is high only together with `done`, and only for auto-modify forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when both high |
| postbyte | input | 8 | Indexed-mode postbyte |
| ext_word | input | 16 | Extension bytes (9-bit form uses low byte) |
| restricted | input | 1 | Reject long-offset and indirect forms |
| reg_x | input | 16 | X register value |
| reg_y | input | 16 | Y register value |
| reg_sp | input | 16 | Stack pointer value |
| reg_pc | input | 16 | Program counter value |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| acc_d | input | 16 | Double accumulator D |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 16 | Pointer read address |
| mem_ack | input | 1 | Pointer read completes, data valid |
| mem_rdata | input | 16 | Pointer word |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base writeback enable |
| wb_sel | output | 2 | Writeback register (0 X, 1 Y, 2 SP, 3 PC) |
| wb_val | output | 16 | Writeback value |
| extra_cyc | output | 2 | Extra cycle count of the form |

## Verification
A wrong decode shows up directly at the ports. It gives a wrong `ea` or `wb_val` on the `done` pulse of the same transaction, one cycle after the accept, or a writeback where none belongs. A wrong family choice between the indirect and direct paths also moves the timing. Then `mem_req` appears or goes missing, and `done` arrives at the wrong cycle relative to the accept or the acknowledge, so a latency check on each transaction catches it at once. A sequencer stuck outside idle keeps `req_ready` low and stalls every later request.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int AW    = 16;
  localparam int PBW   = 8;
  localparam int ACCW  = 8;
  localparam int CYCW  = 2;
  localparam int SELW  = 2;

  typedef logic [AW-1:0] word_t;

  typedef enum logic [2:0] {
    FAM_SHORT, FAM_AUTO, FAM_OFF9, FAM_OFF16, FAM_IND16, FAM_ACC, FAM_INDD
  } fam_e;

  typedef struct packed {
    fam_e            fam;
    logic [SELW-1:0] base_sel;
    logic [1:0]      acc_sel;
    logic            post;
    logic [3:0]      nib;
    logic            sign9;
    logic [4:0]      off5;
  } dec_t;

  function automatic word_t sext5(input logic [4:0] v);
    return {{(AW-5){v[4]}}, v};
  endfunction

  function automatic word_t auto_amount(input logic [3:0] n);
    if (n[3]) return {{(AW-4){1'b1}}, n};
    return {{(AW-4){1'b0}}, n} + word_t'(1);
  endfunction

  function automatic word_t sext9(input logic s, input logic [7:0] b);
    return {{(AW-8){s}}, b};
  endfunction

  function automatic word_t zext8(input logic [ACCW-1:0] b);
    return {{(AW-ACCW){1'b0}}, b};
  endfunction

  function automatic word_t pick_base(input logic [SELW-1:0] sel,
                                      input word_t x, input word_t y,
                                      input word_t sp, input word_t pc);
    case (sel)
      2'd0:    return x;
      2'd1:    return y;
      2'd2:    return sp;
      default: return pc;
    endcase
  endfunction
endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
(
  input  logic [PBW-1:0] pb,
  output dec_t           dec
);
  always_comb begin
    dec          = '0;
    dec.off5     = pb[4:0];
    dec.nib      = pb[3:0];
    dec.post     = pb[4];
    dec.sign9    = pb[0];
    dec.acc_sel  = pb[1:0];
    if (!pb[5]) begin
      dec.fam      = FAM_SHORT;
      dec.base_sel = pb[7:6];
    end else if (pb[7:6] != 2'b11) begin
      dec.fam      = FAM_AUTO;
      dec.base_sel = pb[7:6];
    end else begin
      dec.base_sel = pb[4:3];
      if (pb[2:0] == 3'b011)
        dec.fam = FAM_IND16;
      else if (!pb[2])
        dec.fam = pb[1] ? FAM_OFF16 : FAM_OFF9;
      else
        dec.fam = (pb[1:0] == 2'b11) ? FAM_INDD : FAM_ACC;
    end
  end
endmodule

// File: rtl/idx_ea_addr.sv
module idx_ea_addr
  import idx_ea_pkg::*;
(
  input  dec_t            dec,
  input  word_t           ext_word,
  input  logic            restricted,
  input  word_t           reg_x,
  input  word_t           reg_y,
  input  word_t           reg_sp,
  input  word_t           reg_pc,
  input  logic [ACCW-1:0] acc_a,
  input  logic [ACCW-1:0] acc_b,
  input  word_t           acc_d,
  output word_t           addr,
  output logic            need_mem,
  output logic            wb_en,
  output logic [SELW-1:0] wb_sel,
  output word_t           wb_val,
  output logic [CYCW-1:0] extra,
  output logic            rejected
);
  word_t base, amt, upd, acc_off;
  logic  long_form;

  assign base    = pick_base(dec.base_sel, reg_x, reg_y, reg_sp, reg_pc);
  assign amt     = auto_amount(dec.nib);
  assign upd     = base + amt;
  assign wb_sel  = dec.base_sel;

  always_comb begin
    case (dec.acc_sel)
      2'd0:    acc_off = zext8(acc_a);
      2'd1:    acc_off = zext8(acc_b);
      default: acc_off = acc_d;
    endcase
  end

  always_comb begin
    addr      = '0;
    need_mem  = 1'b0;
    wb_en     = 1'b0;
    wb_val    = '0;
    extra     = '0;
    long_form = 1'b0;
    case (dec.fam)
      FAM_SHORT: addr = base + sext5(dec.off5);
      FAM_AUTO: begin
        addr   = dec.post ? base : upd;
        wb_en  = 1'b1;
        wb_val = upd;
      end
      FAM_OFF9: begin
        addr      = base + sext9(dec.sign9, ext_word[7:0]);
        extra     = CYCW'(1);
        long_form = 1'b1;
      end
      FAM_OFF16: begin
        addr      = base + ext_word;
        extra     = CYCW'(1);
        long_form = 1'b1;
      end
      FAM_IND16: begin
        addr      = base + ext_word;
        need_mem  = 1'b1;
        extra     = CYCW'(1);
        long_form = 1'b1;
      end
      FAM_ACC:  addr = base + acc_off;
      FAM_INDD: begin
        addr      = base + acc_d;
        need_mem  = 1'b1;
        extra     = CYCW'(1);
        long_form = 1'b1;
      end
      default: addr = '0;
    endcase
    rejected = long_form & restricted;
    if (rejected) begin
      addr     = '0;
      need_mem = 1'b0;
      extra    = '0;
    end
  end
endmodule

// File: rtl/idx_ea_ctrl.sv
module idx_ea_ctrl
  import idx_ea_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  word_t           calc_addr,
  input  logic            calc_mem,
  input  logic            calc_wb_en,
  input  logic [SELW-1:0] calc_wb_sel,
  input  word_t           calc_wb_val,
  input  logic [CYCW-1:0] calc_extra,
  input  logic            mem_ack,
  input  word_t           mem_rdata,
  output logic            idle,
  output logic            mem_req,
  output word_t           mem_addr,
  output logic            done,
  output word_t           ea,
  output logic            wb_en,
  output logic [SELW-1:0] wb_sel,
  output word_t           wb_val,
  output logic [CYCW-1:0] extra_cyc
);
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_RESP} state_e;
  state_e          state;
  word_t           addr_q, wbv_q;
  logic            wbe_q;
  logic [SELW-1:0] wbs_q;
  logic [CYCW-1:0] ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      wbv_q  <= '0;
      wbe_q  <= 1'b0;
      wbs_q  <= '0;
      ext_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          addr_q <= calc_addr;
          wbe_q  <= calc_wb_en;
          wbs_q  <= calc_wb_sel;
          wbv_q  <= calc_wb_val;
          ext_q  <= calc_extra;
          state  <= calc_mem ? ST_MEM : ST_RESP;
        end
        ST_MEM: if (mem_ack) begin
          addr_q <= mem_rdata;
          state  <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign mem_req   = (state == ST_MEM);
  assign mem_addr  = addr_q;
  assign done      = (state == ST_RESP);
  assign ea        = addr_q;
  assign wb_en     = done & wbe_q;
  assign wb_sel    = wbs_q;
  assign wb_val    = wbv_q;
  assign extra_cyc = ext_q;
endmodule

// File: rtl/idx_ea_gen.sv
module idx_ea_gen
  import idx_ea_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PBW-1:0]  postbyte,
  input  logic [AW-1:0]   ext_word,
  input  logic            restricted,
  input  logic [AW-1:0]   reg_x,
  input  logic [AW-1:0]   reg_y,
  input  logic [AW-1:0]   reg_sp,
  input  logic [AW-1:0]   reg_pc,
  input  logic [ACCW-1:0] acc_a,
  input  logic [ACCW-1:0] acc_b,
  input  logic [AW-1:0]   acc_d,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  input  logic [AW-1:0]   mem_rdata,
  output logic            done,
  output logic [AW-1:0]   ea,
  output logic            wb_en,
  output logic [SELW-1:0] wb_sel,
  output logic [AW-1:0]   wb_val,
  output logic [CYCW-1:0] extra_cyc
);
  dec_t            dec;
  word_t           calc_addr, calc_wb_val;
  logic            calc_mem, calc_wb_en, calc_rejected;
  logic [SELW-1:0] calc_wb_sel;
  logic [CYCW-1:0] calc_extra;
  logic            idle;
  logic            accept;
  logic            mem_fire;

  assign req_ready = idle;
  assign accept    = req_valid & idle;
  assign mem_fire  = mem_req & mem_ack;

  idx_ea_decode u_dec (.pb(postbyte), .dec(dec));

  idx_ea_addr u_addr (
    .dec(dec), .ext_word(ext_word), .restricted(restricted),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d),
    .addr(calc_addr), .need_mem(calc_mem), .wb_en(calc_wb_en),
    .wb_sel(calc_wb_sel), .wb_val(calc_wb_val), .extra(calc_extra),
    .rejected(calc_rejected)
  );

  idx_ea_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .calc_addr(calc_addr), .calc_mem(calc_mem), .calc_wb_en(calc_wb_en),
    .calc_wb_sel(calc_wb_sel), .calc_wb_val(calc_wb_val),
    .calc_extra(calc_extra), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .idle(idle), .mem_req(mem_req), .mem_addr(mem_addr), .done(done),
    .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
    .extra_cyc(extra_cyc)
  );
endmodule

// File: rtl/idx_ea_gen_chk.sv
module idx_ea_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       accept,
  input logic [7:0] postbyte,
  input logic       restricted,
  input logic       mem_req,
  input logic       mem_ack,
  input logic [15:0] mem_addr,
  input logic       calc_rejected,
  input logic       done,
  input logic       wb_en,
  input logic [1:0] wb_sel,
  input logic [1:0] extra_cyc
);
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !done && !mem_req);

  p_done_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(accept) || $past(mem_req && mem_ack));

  p_restr_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && restricted |=> !mem_req);

  p_reject_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && calc_rejected |=> done && extra_cyc == 2'd0 && !wb_en);

  p_short_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !postbyte[5] |=> done && !wb_en && extra_cyc == 2'd0);

  p_auto_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && postbyte[5] && postbyte[7:6] != 2'b11
      |=> done && wb_en && wb_sel == $past(postbyte[7:6]));

  p_wb_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  p_extra_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> extra_cyc <= 2'd1);
endmodule

bind idx_ea_gen idx_ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .accept(accept),
  .postbyte(postbyte), .restricted(restricted), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .calc_rejected(calc_rejected),
  .done(done), .wb_en(wb_en), .wb_sel(wb_sel), .extra_cyc(extra_cyc)
);

// File: tb/idx_ea_gen_tb.sv
module idx_ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  postbyte = '0;
  logic [15:0] ext_word = '0;
  logic        restricted = 1'b0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
  logic [7:0]  acc_a = '0, acc_b = '0;
  logic [15:0] acc_d = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        done;
  logic [15:0] ea;
  logic        wb_en;
  logic [1:0]  wb_sel;
  logic [15:0] wb_val;
  logic [1:0]  extra_cyc;

  always #10 clk = ~clk;

  idx_ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .postbyte(postbyte), .ext_word(ext_word), .restricted(restricted),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .acc_d(acc_d), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .ea(ea), .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
    .extra_cyc(extra_cyc)
  );

  typedef struct {
    logic [15:0] ea;
    logic        wb_en;
    logic [1:0]  wb_sel;
    logic [15:0] wb_val;
    logic [1:0]  extra;
    logic        ind;
    int          acc_cyc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  int   cyc = 0;
  int   ack_cyc = 0;
  int   rd_cnt = 0;
  int   rd_seen = 0;
  bit   ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  endtask

  // Reference model written from the requirement list.
  function automatic exp_t model(input logic [7:0] pb, input logic [15:0] ext,
                                 input bit rs);
    exp_t e;
    logic [15:0] bases [4];
    logic [15:0] b, p;
    int amt;
    bases[0] = reg_x; bases[1] = reg_y; bases[2] = reg_sp; bases[3] = reg_pc;
    e.wb_en = 0; e.wb_sel = 0; e.wb_val = 0; e.extra = 0; e.ind = 0;
    e.acc_cyc = 0;
    if (pb[7] && pb[6] && pb[5]) begin
      b = bases[pb[4:3]];
      case (pb[2:0])
        3'b000, 3'b001: begin e.ea = b + {{8{pb[0]}}, ext[7:0]}; e.extra = 1; e.tag = "R4"; end
        3'b010: begin e.ea = b + ext; e.extra = 1; e.tag = "R5"; end
        3'b011: begin p = b + ext; e.ea = memf(p); e.extra = 1; e.ind = 1; e.tag = "R6"; end
        3'b100: begin e.ea = b + {8'h00, acc_a}; e.tag = "R7"; end
        3'b101: begin e.ea = b + {8'h00, acc_b}; e.tag = "R7"; end
        3'b110: begin e.ea = b + acc_d; e.tag = "R7"; end
        default: begin p = b + acc_d; e.ea = memf(p); e.extra = 1; e.ind = 1; e.tag = "R8"; end
      endcase
      if (rs && e.tag != "R7") begin
        e.ea = 0; e.extra = 0; e.ind = 0; e.tag = "R9";
      end
    end else if (!pb[5]) begin
      b = bases[pb[7:6]];
      amt = pb[4] ? int'(pb[4:0]) - 32 : int'(pb[4:0]);
      e.ea = b + 16'(amt);
      e.tag = "R1";
    end else begin
      b = bases[pb[7:6]];
      amt = pb[3] ? int'(pb[3:0]) - 16 : int'(pb[3:0]) + 1;
      e.wb_en = 1; e.wb_sel = pb[7:6]; e.wb_val = b + 16'(amt);
      e.ea = pb[4] ? b : e.wb_val;
      e.tag = pb[4] ? "R3" : "R2";
    end
    return e;
  endfunction

  task automatic set_regs(input logic [15:0] x, input logic [15:0] y,
                          input logic [15:0] sp, input logic [15:0] pc,
                          input logic [7:0] a, input logic [7:0] b,
                          input logic [15:0] d);
    reg_x = x; reg_y = y; reg_sp = sp; reg_pc = pc;
    acc_a = a; acc_b = b; acc_d = d;
  endtask

  task automatic send(input logic [7:0] pb, input logic [15:0] ext, input bit rs);
    exp_t e;
    @(negedge clk);
    postbyte = pb; ext_word = ext; restricted = rs; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    e = model(pb, ext, rs);
    e.acc_cyc = cyc;
    q.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // Memory responder with a rotating wait of 0..3 cycles.
  initial begin
    int dly = 0;
    int wcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (wcnt >= dly) begin
          mem_ack = 1'b1;
          mem_rdata = memf(mem_addr);
          ack_cyc = cyc;
          rd_cnt++;
          wcnt = 0;
          dly = (dly + 1) % 4;
        end else wcnt++;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        int reads;
        if (q.size() == 0) begin
          check(0, "R11", "unexpected done", 16'(done), 16'd0);
        end else begin
          e = q.pop_front();
          reads = rd_cnt - rd_seen;
          rd_seen = rd_cnt;
          check(ea == e.ea, e.tag, "ea", ea, e.ea);
          check(wb_en == e.wb_en, "R12", "wb_en", 16'(wb_en), 16'(e.wb_en));
          if (e.wb_en) begin
            check(wb_sel == e.wb_sel, "R2", "wb_sel", 16'(wb_sel), 16'(e.wb_sel));
            check(wb_val == e.wb_val, "R2", "wb_val", wb_val, e.wb_val);
          end
          check(extra_cyc == e.extra, e.tag, "extra_cyc", 16'(extra_cyc), 16'(e.extra));
          check(reads == int'(e.ind), e.tag, "memory reads", 16'(reads), 16'(e.ind));
          if (e.ind)
            check(cyc == ack_cyc + 1, "R11", "done after ack", 16'(cyc), 16'(ack_cyc + 1));
          else
            check(cyc == e.acc_cyc + 1, "R11", "done after accept", 16'(cyc), 16'(e.acc_cyc + 1));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R11", "watchdog expired", 16'(q.size()), 16'd0);
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11", "reset ready", 16'(req_ready), 16'd1);
    check(done == 1'b0, "R11", "reset done", 16'(done), 16'd0);
    check(mem_req == 1'b0, "R11", "reset mem_req", 16'(mem_req), 16'd0);

    set_regs(16'h1000, 16'h2000, 16'h3000, 16'h4000, 8'hFF, 8'h80, 16'h0123);
    // R1 short offsets, every base, both signs
    send(8'h0F, 16'h0, 0);  send(8'h50, 16'h0, 0);
    send(8'h9F, 16'h0, 0);  send(8'hC1, 16'h0, 0);
    // R2/R3 auto-modify: +1, +8, -1, -8, pre and post
    send(8'h20, 16'h0, 0);  send(8'h27, 16'h0, 0);
    send(8'h6F, 16'h0, 0);  send(8'hA8, 16'h0, 0);
    send(8'h30, 16'h0, 0);  send(8'h78, 16'h0, 0);
    // R4 9-bit offsets positive and negative
    send(8'hE0, 16'hAA7F, 0); send(8'hE9, 16'h0010, 0);
    // R5 16-bit offset
    send(8'hF2, 16'hBEEF, 0);
    // R6 16-bit indirect
    send(8'hE3, 16'h0020, 0); send(8'hFB, 16'hFFF0, 0);
    // R7 accumulator offsets: A and B zero-extended, D
    send(8'hE4, 16'h0, 0); send(8'hED, 16'h0, 0); send(8'hF6, 16'h0, 0);
    // R8 D indirect
    send(8'hE7, 16'h0, 0); send(8'hFF, 16'h0, 0);
    // R9 restricted mode: rejected forms and unaffected ones
    send(8'hE0, 16'h1234, 1); send(8'hE2, 16'h1234, 1);
    send(8'hE3, 16'h1234, 1); send(8'hE7, 16'h1234, 1);
    send(8'h05, 16'h0, 1);    send(8'h22, 16'h0, 1); send(8'hE5, 16'h0, 1);
    // R10 wrap-around
    set_regs(16'hFFFF, 16'h0000, 16'hFFFC, 16'hFFF8, 8'hFF, 8'h01, 16'hFFFF);
    send(8'h01, 16'h0, 0); send(8'h50, 16'h0, 0); send(8'h60, 16'h0, 0);
    send(8'h80 | 8'h27, 16'h0, 0); send(8'hF2, 16'h0010, 0); send(8'hE6, 16'h0, 0);

    lf = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      logic [15:0] r1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r1 = lf * 16'd40503;
      set_regs(lf, r1, lf ^ 16'h5555, r1 + 16'h0101, lf[7:0], r1[15:8], lf ^ r1);
      send(lf[15:8], r1, (i % 5) == 0);
    end

    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule